// File: doc/BRIEF.md
# Interrupt Flag and Enable Register

This block collects three kinds of timekeeping event (a periodic tick, an alarm match and the end of a time update) and keeps a sticky flag for each one. Each event arrives as a single-cycle pulse from logic outside the block. The block masks the flags with three enable bits. It drives a summary bit and an active-high interrupt request whenever an enabled flag is set.

The host reaches two byte-wide registers through an indexed read port. The status register reports the three flags and the summary bit. Reading it clears the flags, so the host acknowledges an interrupt with a single read. The validity register reports in its top bit whether the backing supply kept the stored time and memory contents valid.

Read data is registered. It is valid in the cycle after the read strobe and returns to zero when no read is requested.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all three flags are clear, `irq` is low and `rd_data` is zero.
- R2: A pulse on an event input sets its flag from the next cycle on, whether or not its enable is set. The status byte layout is: bit 6 periodic, bit 5 alarm, bit 4 update-ended.
- R3: Status bit 7 (the summary bit) is 1 exactly when at least one flag is set together with its enable.
- R4: `irq` equals the summary bit. It rises in the cycle after an enabled event pulse and follows enable changes with no added delay.
- R5: A read with `rd_idx` = 12 returns the status byte in `rd_data` in the next cycle. The same clock edge clears all flags, so `irq` is low from that cycle on.
- R6: An event pulse in the same cycle as a clearing status read leaves that flag set after the read.
- R7: Status bits 3:0 read as zero. A read with `rd_idx` = 13 returns `supply_ok` in bit 7 and zeros in bits 6:0.
- R8: A read of any index other than 12 returns zero when the index is not 13, and it never clears the flags.
- R9: When `rd_en` is low, `rd_data` is zero in the next cycle.
- R10: A set flag stays set, whatever events or enable changes occur, until a status read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_periodic | input | 1 | One-cycle periodic event pulse |
| evt_alarm | input | 1 | One-cycle alarm event pulse |
| evt_update | input | 1 | One-cycle update-ended event pulse |
| en_periodic | input | 1 | Interrupt enable for the periodic flag |
| en_alarm | input | 1 | Interrupt enable for the alarm flag |
| en_update | input | 1 | Interrupt enable for the update-ended flag |
| supply_ok | input | 1 | Backing supply reports valid memory and time |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | IDX_W (4) | Register index of the read |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions check on every cycle that:
- each flag is set after its event pulse;
- a flag holds until a status read clears it;
- a clearing read without a simultaneous event empties the flag;
- the summary bit returned by a status read matches the `irq` level of the cycle in which the read was taken;
- idle cycles return zero data.

Only the bench scenarios show the full status byte for every combination of event and enable patterns. The same applies to the collision of events with the clearing read, to the index sweep with its non-clearing reads, and to the tracking of `supply_ok` in the validity register.

// File: rtl/irq_flag_pkg.sv
// Package: shared bit positions, register indices and sizes for the
// interrupt flag block. Assumes an 8-bit register read port.
package irq_flag_pkg;
    localparam int NUM_SRC   = 3;
    localparam int DATA_W    = 8;
    // Source slots inside the internal flag vector
    localparam int SRC_UPD   = 0;
    localparam int SRC_ALM   = 1;
    localparam int SRC_PER   = 2;
    // Position of the flag vector and summary bit in the status byte
    localparam int STAT_LSB  = 4;
    localparam int STAT_SUM  = 7;
    localparam int VALID_BIT = 7;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // Builds the status byte from the flags and the summary bit
    function automatic logic [DATA_W-1:0] pack_status(input src_vec_t f, input logic s);
        logic [DATA_W-1:0] b;
        b = '0;
        b[STAT_SUM] = s;
        b[STAT_LSB +: NUM_SRC] = f;
        return b;
    endfunction
endpackage

// File: rtl/irq_flag_cell.sv
// Module: one sticky event flag. Sets on an event pulse and clears on a
// clearing read. An event in the same cycle as the clear wins (R6).
// Assumes events are single-cycle pulses synchronous to clk.
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic flag
);
    // Set-dominant sticky flag register
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= evt | (flag & ~clr);
    end

    a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);
    a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !flag);
endmodule

// File: rtl/irq_flag_summary.sv
// Module: masks the flags with their enables and forms the summary bit.
// Purely combinational, so enable changes act in the same cycle (R3, R4).
module irq_flag_summary
    import irq_flag_pkg::*;
(
    input  src_vec_t flags,
    input  src_vec_t enables,
    output logic     summary
);
    // OR-reduce the enabled flags
    always_comb summary = |(flags & enables);
endmodule

// File: rtl/irq_flag_readout.sv
// Module: decodes the indexed read port, registers the read data and
// issues the clear strobe for the status register.
// Assumes a read is a single-cycle strobe with a stable index.
module irq_flag_readout
    import irq_flag_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int STAT_IDX  = 12,
    parameter int VALID_IDX = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  src_vec_t          flags,
    input  logic              summary,
    input  logic              supply_ok,
    output logic              clr_stat,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [IDX_W-1:0] STAT_SEL  = IDX_W'(STAT_IDX);
    localparam logic [IDX_W-1:0] VALID_SEL = IDX_W'(VALID_IDX);

    logic [DATA_W-1:0] rd_next;

    // Clear strobe: only a read of the status index clears
    always_comb clr_stat = rd_en && (rd_idx == STAT_SEL);

    // Read mux: pick the addressed register, or zero
    always_comb begin
        rd_next = '0;
        if (rd_en) begin
            if (rd_idx == STAT_SEL)
                rd_next = pack_status(flags, summary);
            else if (rd_idx == VALID_SEL)
                rd_next[VALID_BIT] = supply_ok;
        end
    end

    // Read data register
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_next;
    end

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));
    a_r7_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stat |=> (rd_data[STAT_LSB-1:0] == '0));
endmodule

// File: rtl/irq_flag_ctrl.sv
// Module: top of the interrupt flag and enable register. Holds a sticky
// flag per event source, drives irq from the enabled flags, and serves
// the status (clear-on-read) and validity registers on an indexed port.
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int STAT_IDX  = 12,
    parameter int VALID_IDX = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_periodic,
    input  logic              evt_alarm,
    input  logic              evt_update,
    input  logic              en_periodic,
    input  logic              en_alarm,
    input  logic              en_update,
    input  logic              supply_ok,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    src_vec_t evt_v, en_v, flag_v;
    logic     clr_stat, summary;

    // Gather the per-source inputs into vectors
    always_comb begin
        evt_v[SRC_PER] = evt_periodic;
        evt_v[SRC_ALM] = evt_alarm;
        evt_v[SRC_UPD] = evt_update;
        en_v[SRC_PER]  = en_periodic;
        en_v[SRC_ALM]  = en_alarm;
        en_v[SRC_UPD]  = en_update;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        irq_flag_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .evt  (evt_v[i]),
            .clr  (clr_stat),
            .flag (flag_v[i])
        );
    end

    irq_flag_summary u_sum (
        .flags  (flag_v),
        .enables(en_v),
        .summary(summary)
    );

    irq_flag_readout #(
        .IDX_W    (IDX_W),
        .STAT_IDX (STAT_IDX),
        .VALID_IDX(VALID_IDX)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .flags    (flag_v),
        .summary  (summary),
        .supply_ok(supply_ok),
        .clr_stat (clr_stat),
        .rd_data  (rd_data)
    );

    // Interrupt request mirrors the summary bit
    always_comb irq = summary;

    a_r4_read_summary_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stat |=> (rd_data[STAT_SUM] == $past(irq)));
    a_r3_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_v != '0));
endmodule

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_periodic = 0, evt_alarm = 0, evt_update = 0;
    logic       en_periodic = 0, en_alarm = 0, en_update = 0;
    logic       supply_ok = 0;
    logic       rd_en = 0;
    logic [3:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic       irq;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    irq_flag_ctrl dut (.*);

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // mask bit2 periodic, bit1 alarm, bit0 update
    task automatic set_evt(logic [2:0] m);
        {evt_periodic, evt_alarm, evt_update} = m;
    endtask
    task automatic set_en(logic [2:0] m);
        {en_periodic, en_alarm, en_update} = m;
    endtask

    function automatic logic [7:0] stat(logic [2:0] f, logic [2:0] e);
        return {|(f & e), f, 4'b0000};
    endfunction

    task automatic rd(logic [3:0] idx);
        rd_en = 1; rd_idx = idx; tick(); rd_en = 0;
    endtask

    initial begin
        repeat (3) tick();
        check("R1 reset rd_data", rd_data, 8'h00);
        check("R1 reset irq", {7'b0, irq}, 8'h00);
        rst_n = 1; tick();
        rd(4'd12);
        check("R1 flags clear after reset", rd_data, 8'h00);

        // Sweep every event pattern against every enable pattern
        for (int m = 0; m < 8; m++) begin
            for (int e = 0; e < 8; e++) begin
                set_en(3'(e));
                set_evt(3'(m)); tick(); set_evt(3'b000);
                check($sformatf("R4 irq m=%0d e=%0d", m, e), {7'b0, irq},
                      {7'b0, |(3'(m) & 3'(e))});
                tick(); // R10: flags hold with no read
                rd(4'd12);
                check($sformatf("R2 R3 R5 status m=%0d e=%0d", m, e), rd_data,
                      stat(3'(m), 3'(e)));
                check("R5 irq low after read", {7'b0, irq}, 8'h00);
                rd(4'd12);
                check("R5 flags cleared", rd_data, 8'h00);
            end
        end

        // R4: enable change acts on irq at once, flag stays (R10)
        set_en(3'b000); set_evt(3'b010); tick(); set_evt(3'b000);
        check("R4 irq masked", {7'b0, irq}, 8'h00);
        set_en(3'b010); #1;
        check("R4 irq follows enable", {7'b0, irq}, 8'h01);
        set_en(3'b000); #1;
        check("R10 irq drops on disable", {7'b0, irq}, 8'h00);
        set_en(3'b010); #1;
        check("R10 flag kept across enable toggle", {7'b0, irq}, 8'h01);
        rd(4'd12); set_en(3'b000);

        // R6: event colliding with clearing read survives
        for (int s = 0; s < 3; s++) begin
            set_evt(3'b001 << s); tick(); set_evt(3'b000);
            set_en(3'b111);
            rd_en = 1; rd_idx = 4'd12; set_evt(3'b111 ^ (3'b001 << s));
            tick(); rd_en = 0; set_evt(3'b000);
            check("R6 collision read value", rd_data, stat(3'b001 << s, 3'b111));
            rd(4'd12);
            check("R6 colliding events kept", rd_data, stat(3'b111 ^ (3'b001 << s), 3'b111));
            rd(4'd12);
            set_en(3'b000);
        end

        // R7/R8: index sweep with flags set, other reads do not clear
        set_evt(3'b101); tick(); set_evt(3'b000);
        for (int v = 0; v < 2; v++) begin
            supply_ok = v[0];
            for (int i = 0; i < 16; i++) begin
                if (i == 12) continue;
                rd(4'(i));
                check($sformatf("R7 R8 index %0d", i), rd_data,
                      (i == 13) ? {v[0], 7'b0} : 8'h00);
            end
        end
        rd(4'd12);
        check("R8 other reads did not clear", rd_data, stat(3'b101, 3'b000));

        // R9: idle cycle returns zero
        set_evt(3'b111); tick(); set_evt(3'b000);
        rd_idx = 4'd12; tick();
        check("R9 idle rd_data zero", rd_data, 8'h00);

        // R1: reset clears live flags
        rst_n = 0; tick(); rst_n = 1; tick();
        set_en(3'b111); #1;
        check("R1 irq low after reset", {7'b0, irq}, 8'h00);
        rd(4'd12);
        check("R1 flags cleared by reset", rd_data, 8'h00);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule